// File: doc/BRIEF.md
# Dual-Output Prioritized Interrupt Controller

This block collects 64 level-sensitive interrupt request lines, masks each with its own enable bit and steers every enabled request to one of two processor lines: a fast request line or a normal request line, chosen per source by a select bit. The controller never sets or clears a request. It only mirrors the lines, so a request goes away only when the device that raised it drops its line, and the change shows after a short pipeline delay.

For each of the two outputs the block also keeps a 7-bit winner register. It names the pending source that software should service first. Sources 32 to 63 form an error class that can be given absolute precedence over sources 0 to 31. When that precedence is off, the lowest source number wins across all 64 sources. A small word-addressed register bus gives read/write access to the enable, select and precedence registers, and read access to the status and winner registers. A read returns data in the same cycle as the address; a write takes effect at the next clock edge.

Top module: `intc_dual_prio`

## Requirements
- R1: Raw status is read at address 0 (sources 0..31, bit i = source i) and address 1 (sources 32..63, bit i = source 32+i). Each bit mirrors its input line, both rising and falling. It ignores the enable and select bits.
- R2: Enable registers sit at addresses 2 (sources 0..31) and 3 (sources 32..63), and select registers at addresses 4 and 5, with the same bit layout as R1. All four read back what was written and reset to zero.
- R3: Normal-line status at addresses 6 and 7 equals raw AND enable AND NOT select. Fast-line status at addresses 8 and 9 equals raw AND enable AND select. A select value of 1 means the fast line.
- R4: `irq_out` is high exactly when any normal-line status bit was set in the previous cycle. `fiq_out` behaves the same way for the fast-line status.
- R5: A source whose enable bit is 0 has no effect on the routed status, on either output or on either winner register, even while its line is high.
- R6: The winner registers are read at address 10 (normal line) and address 11 (fast line) in bits 6:0, and also appear on `irq_idx` and `fiq_idx`. Bit 6 is a valid flag and bits 5:0 hold the source number. The whole value is zero when no source is pending on that line.
- R7: While bit 0 of the precedence register at address 12 is 1, any pending source in 32..63 beats every source in 0..31. Within the winning class the lowest number wins.
- R8: While that bit is 0, the lowest pending source number wins across all 64 sources. The bit resets to 1, reads back as written, and the other bits of address 12 read as zero.
- R9: A line change driven before rising edge k appears in raw status after edge k+2 and not earlier. It appears on the outputs and winner registers after edge k+3 and not earlier. This holds for both assertion and release.
- R10: Addresses 13 to 15 read as zero, and writes to read-only addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_lines | input | 64 | Level-sensitive request lines, bit i = source i |
| bus_addr | input | 4 | Register word address |
| bus_wen | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| irq_out | output | 1 | Normal request line to the processor |
| fiq_out | output | 1 | Fast request line to the processor |
| irq_idx | output | 7 | Normal-line winner {valid, source number} |
| fiq_idx | output | 7 | Fast-line winner {valid, source number} |

## Verification
The bench aims at the class boundary: source 0 and source 63 pending together, which must report 63 with precedence on and 0 with it off. A design that compares only numbers, or that inverts the class order, reports the wrong source. Sources that are active but disabled check that masking happens before routing. A design that masks late still raises a line or shows a ghost winner. Edge-exact sampling around an assertion and a release catches a missing or extra pipeline stage. Random line, enable and select patterns then compare all status and winner registers against a model that ranks sources independently of the RTL.

// File: rtl/intc_pkg.sv
package intc_pkg;

    localparam int NSRC     = 64;
    localparam int BANK_W   = 32;
    localparam int NBANK    = NSRC / BANK_W;
    localparam int IDX_W    = $clog2(NSRC);
    localparam int WIN_W    = IDX_W + 1;
    localparam int ADDR_W   = 4;
    localparam int NOUT     = 2;

    // word addresses
    localparam int AD_RAW   = 0;
    localparam int AD_EN    = 2;
    localparam int AD_SEL   = 4;
    localparam int AD_NST   = 6;
    localparam int AD_FST   = 8;
    localparam int AD_NWIN  = 10;
    localparam int AD_FWIN  = 11;
    localparam int AD_PREC  = 12;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] num;
    } win_t;

    typedef enum logic {
        OUT_NORMAL = 1'b0,
        OUT_FAST   = 1'b1
    } out_kind_e;

    // lowest set bit within [lo, hi], zero when none is set
    function automatic win_t first_set(input src_vec_t v, input int lo, input int hi);
        win_t w;
        w = '0;
        for (int i = hi; i >= lo; i--) begin
            if (v[i]) begin
                w.valid = 1'b1;
                w.num   = IDX_W'(i);
            end
        end
        return w;
    endfunction

    function automatic win_t choose_winner(input src_vec_t v, input logic err_first);
        if (err_first && (|v[NSRC-1:BANK_W]))
            return first_set(v, BANK_W, NSRC-1);
        return first_set(v, 0, NSRC-1);
    endfunction

endpackage

// File: rtl/intc_sync.sv
module intc_sync
    import intc_pkg::*;
#(
    parameter int W = NSRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
            s2 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
            q  <= s2;
        end
    end
endmodule

// File: rtl/intc_route.sv
module intc_route
    import intc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t pend,
    input  logic     err_first,
    output logic     req_q,
    output win_t     win_q
);
    win_t win_d;

    always_comb win_d = choose_winner(pend, err_first);

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            win_q <= '0;
        end else begin
            req_q <= |pend;
            win_q <= win_d;
        end
    end
endmodule

// File: rtl/intc_regs.sv
module intc_regs
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic [BANK_W-1:0] wdata,
    input  src_vec_t          raw,
    input  src_vec_t          nstat,
    input  src_vec_t          fstat,
    input  win_t              nwin,
    input  win_t              fwin,
    output src_vec_t          en_q,
    output src_vec_t          sel_q,
    output logic              prec_q,
    output logic [BANK_W-1:0] rdata
);
    localparam int PAD_W = BANK_W - WIN_W;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                en_q[b*BANK_W +: BANK_W]  <= '0;
                sel_q[b*BANK_W +: BANK_W] <= '0;
            end else if (wen) begin
                if (addr == ADDR_W'(AD_EN + b))
                    en_q[b*BANK_W +: BANK_W] <= wdata;
                if (addr == ADDR_W'(AD_SEL + b))
                    sel_q[b*BANK_W +: BANK_W] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            prec_q <= 1'b1;
        else if (wen && addr == ADDR_W'(AD_PREC))
            prec_q <= wdata[0];
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (addr == ADDR_W'(AD_RAW + b)) rdata = raw[b*BANK_W +: BANK_W];
            if (addr == ADDR_W'(AD_EN  + b)) rdata = en_q[b*BANK_W +: BANK_W];
            if (addr == ADDR_W'(AD_SEL + b)) rdata = sel_q[b*BANK_W +: BANK_W];
            if (addr == ADDR_W'(AD_NST + b)) rdata = nstat[b*BANK_W +: BANK_W];
            if (addr == ADDR_W'(AD_FST + b)) rdata = fstat[b*BANK_W +: BANK_W];
        end
        if (addr == ADDR_W'(AD_NWIN)) rdata = {{PAD_W{1'b0}}, nwin};
        if (addr == ADDR_W'(AD_FWIN)) rdata = {{PAD_W{1'b0}}, fwin};
        if (addr == ADDR_W'(AD_PREC)) rdata = {{(BANK_W-1){1'b0}}, prec_q};
    end
endmodule

// File: rtl/intc_dual_prio.sv
module intc_dual_prio
    import intc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_lines,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wen,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              fiq_out,
    output logic [WIN_W-1:0]  irq_idx,
    output logic [WIN_W-1:0]  fiq_idx
);
    src_vec_t raw_q, en_q, sel_q;
    src_vec_t nstat_w, fstat_w;
    logic     prec_on;
    src_vec_t pend_v [NOUT];
    logic     req_v  [NOUT];
    win_t     win_v  [NOUT];

    intc_sync #(.W(NSRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (src_lines),
        .q   (raw_q)
    );

    assign nstat_w = raw_q & en_q & ~sel_q;
    assign fstat_w = raw_q & en_q &  sel_q;

    for (genvar g = 0; g < NOUT; g++) begin : g_out
        assign pend_v[g] = (out_kind_e'(g) == OUT_FAST) ? fstat_w : nstat_w;
        intc_route u_route (
            .clk       (clk),
            .rst       (rst),
            .pend      (pend_v[g]),
            .err_first (prec_on),
            .req_q     (req_v[g]),
            .win_q     (win_v[g])
        );
    end

    assign irq_out = req_v[OUT_NORMAL];
    assign fiq_out = req_v[OUT_FAST];
    assign irq_idx = win_v[OUT_NORMAL];
    assign fiq_idx = win_v[OUT_FAST];

    intc_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .addr   (bus_addr),
        .wen    (bus_wen),
        .wdata  (bus_wdata),
        .raw    (raw_q),
        .nstat  (nstat_w),
        .fstat  (fstat_w),
        .nwin   (win_v[OUT_NORMAL]),
        .fwin   (win_v[OUT_FAST]),
        .en_q   (en_q),
        .sel_q  (sel_q),
        .prec_q (prec_on),
        .rdata  (bus_rdata)
    );
endmodule

// File: rtl/intc_checker.sv
module intc_checker
    import intc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             irq_out,
    input logic             fiq_out,
    input logic [WIN_W-1:0] irq_idx,
    input logic [WIN_W-1:0] fiq_idx,
    input src_vec_t         nstat,
    input src_vec_t         fstat,
    input logic             prec_on
);
    src_vec_t prev_n, prev_f;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_n <= '0;
            prev_f <= '0;
        end else begin
            prev_n <= nstat;
            prev_f <= fstat;
        end
    end

    // R3: a source never lands on both lines
    a_r3_disjoint: assert property (@(posedge clk) disable iff (rst)
        (nstat & fstat) == '0);

    // R4: line level follows routed status one cycle later
    a_r4_irq_level: assert property (@(posedge clk) disable iff (rst)
        irq_out == (|prev_n));
    a_r4_fiq_level: assert property (@(posedge clk) disable iff (rst)
        fiq_out == (|prev_f));

    // R6: valid flag agrees with the line, empty winner is zero
    a_r6_irq_valid: assert property (@(posedge clk) disable iff (rst)
        irq_idx[WIN_W-1] == irq_out);
    a_r6_fiq_valid: assert property (@(posedge clk) disable iff (rst)
        fiq_idx[WIN_W-1] == fiq_out);
    a_r6_irq_zero: assert property (@(posedge clk) disable iff (rst)
        !irq_idx[WIN_W-1] |-> irq_idx == '0);
    a_r6_irq_points: assert property (@(posedge clk) disable iff (rst)
        irq_idx[WIN_W-1] |-> prev_n[irq_idx[IDX_W-1:0]]);
    a_r6_fiq_points: assert property (@(posedge clk) disable iff (rst)
        fiq_idx[WIN_W-1] |-> prev_f[fiq_idx[IDX_W-1:0]]);

    // R7: error class wins while precedence is on
    a_r7_irq_err: assert property (@(posedge clk) disable iff (rst)
        (irq_idx[WIN_W-1] && $past(prec_on) && (|prev_n[NSRC-1:BANK_W]))
            |-> irq_idx[IDX_W-1]);
    a_r7_fiq_err: assert property (@(posedge clk) disable iff (rst)
        (fiq_idx[WIN_W-1] && $past(prec_on) && (|prev_f[NSRC-1:BANK_W]))
            |-> fiq_idx[IDX_W-1]);
endmodule

bind intc_dual_prio intc_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_out (irq_out),
    .fiq_out (fiq_out),
    .irq_idx (irq_idx),
    .fiq_idx (fiq_idx),
    .nstat   (nstat_w),
    .fstat   (fstat_w),
    .prec_on (prec_on)
);

// File: tb/test_intc_dual_prio.sv
module test_intc_dual_prio;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [63:0] src_lines;
    logic [3:0]  bus_addr;
    logic        bus_wen;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        irq_out, fiq_out;
    logic [6:0]  irq_idx, fiq_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    logic [63:0] m_en, m_sel;
    logic        m_prec;

    always #(CLK_PERIOD/2) clk = ~clk;

    intc_dual_prio i_intc_dual_prio (
        .clk(clk), .rst(rst), .src_lines(src_lines),
        .bus_addr(bus_addr), .bus_wen(bus_wen), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_out(irq_out), .fiq_out(fiq_out),
        .irq_idx(irq_idx), .fiq_idx(fiq_idx)
    );

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 4'(a);
        bus_wdata = d;
        bus_wen   = 1'b1;
        @(negedge clk);
        bus_wen   = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 4'(a);
        #1 d = bus_rdata;
    endtask

    task automatic settle();
        repeat (6) @(posedge clk);
    endtask

    // ranking: position in service order, independent of the RTL encoder
    function automatic logic [6:0] exp_win(input logic [63:0] v, input logic prec);
        int best_rank = 1000;
        logic [6:0] w = '0;
        for (int i = 0; i < 64; i++) begin
            int rank = prec ? ((i >= 32) ? i - 32 : i + 32) : i;
            if (v[i] && rank < best_rank) begin
                best_rank = rank;
                w = {1'b1, 6'(i)};
            end
        end
        return w;
    endfunction

    task automatic verify_all(input string ctx);
        logic [31:0] d;
        logic [63:0] nst = src_lines & m_en & ~m_sel;
        logic [63:0] fst = src_lines & m_en & m_sel;
        rd(0, d); check(d, src_lines[31:0],  {"R1 raw lo ", ctx});
        rd(1, d); check(d, src_lines[63:32], {"R1 raw hi ", ctx});
        rd(6, d); check(d, nst[31:0],  {"R3 normal lo ", ctx});
        rd(7, d); check(d, nst[63:32], {"R3 normal hi ", ctx});
        rd(8, d); check(d, fst[31:0],  {"R3 fast lo ", ctx});
        rd(9, d); check(d, fst[63:32], {"R3 fast hi ", ctx});
        rd(10, d); check(d, {25'd0, exp_win(nst, m_prec)}, {"R6 normal winner ", ctx});
        rd(11, d); check(d, {25'd0, exp_win(fst, m_prec)}, {"R6 fast winner ", ctx});
        check({31'd0, irq_out}, {31'd0, |nst}, {"R4 irq_out ", ctx});
        check({31'd0, fiq_out}, {31'd0, |fst}, {"R4 fiq_out ", ctx});
    endtask

    task automatic set_cfg(input logic [63:0] en, input logic [63:0] sel, input logic prec);
        m_en = en; m_sel = sel; m_prec = prec;
        wr(2, en[31:0]);  wr(3, en[63:32]);
        wr(4, sel[31:0]); wr(5, sel[63:32]);
        wr(12, {31'd0, prec});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        rst = 1'b1; src_lines = '0; bus_addr = '0; bus_wen = 1'b0; bus_wdata = '0;
        m_en = '0; m_sel = '0; m_prec = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // reset state
        rd(2, d); check(d, 32'd0, "R2 enable reset");
        rd(5, d); check(d, 32'd0, "R2 select reset");
        rd(12, d); check(d, 32'd1, "R8 precedence resets on");
        check({25'd0, irq_idx}, 32'd0, "R6 reset winner");
        check({31'd0, irq_out | fiq_out}, 32'd0, "R4 reset lines");

        // register access, extra bits of address 12, unmapped and read-only
        wr(3, 32'hA5C3_0F17); rd(3, d); check(d, 32'hA5C3_0F17, "R2 enable hi rw");
        wr(4, 32'h1234_5678); rd(4, d); check(d, 32'h1234_5678, "R2 select lo rw");
        wr(12, 32'hFFFF_FFFE); rd(12, d); check(d, 32'd0, "R8 precedence off, upper zero");
        wr(12, 32'h0000_0003); rd(12, d); check(d, 32'd1, "R8 precedence on");
        wr(14, 32'hFFFF_FFFF); rd(14, d); check(d, 32'd0, "R10 unmapped reads zero");
        wr(0, 32'hFFFF_FFFF);  rd(0, d); check(d, 32'd0, "R10 raw not writable");
        wr(10, 32'hFFFF_FFFF); rd(10, d); check(d, 32'd0, "R10 winner not writable");

        // disabled sources ignored
        set_cfg(64'h0, 64'h0, 1'b1);
        @(negedge clk) src_lines = 64'hFFFF_FFFF_FFFF_FFFF;
        settle();
        verify_all("R5 all disabled");
        check({25'd0, irq_idx}, 32'd0, "R5 no winner while disabled");

        // class boundary: 0 and 63 both pending
        set_cfg(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
        @(negedge clk) src_lines = 64'h8000_0000_0000_0001;
        settle();
        rd(10, d); check(d, 32'h7F, "R7 source 63 beats 0");
        set_cfg(m_en, m_sel, 1'b0);
        settle();
        rd(10, d); check(d, 32'h40, "R8 source 0 beats 63");
        set_cfg(m_en, m_sel, 1'b1);
        @(negedge clk) src_lines = 64'h0000_0010_8000_0000;
        settle();
        rd(10, d); check(d, 32'h40 | 32'd36, "R7 error class beats 31");
        // same sources split across lines
        set_cfg(m_en, 64'h0000_0010_0000_0000, 1'b1);
        settle();
        rd(10, d); check(d, 32'h40 | 32'd31, "R3 normal keeps 31");
        rd(11, d); check(d, 32'h40 | 32'd36, "R3 fast takes 36");

        // latency of a rise and of a fall
        set_cfg(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b1);
        @(negedge clk) src_lines = '0;
        settle();
        @(negedge clk) begin bus_addr = 4'd0; src_lines = 64'h20; end
        repeat (2) @(posedge clk); #1;
        check(bus_rdata, 32'd0, "R9 raw not yet after 2 edges");
        @(posedge clk); #1;
        check(bus_rdata, 32'h20, "R9 raw after 3 edges");
        check({31'd0, irq_out}, 32'd0, "R9 irq_out not yet after 3 edges");
        @(posedge clk); #1;
        check({31'd0, irq_out}, 32'd1, "R9 irq_out after 4 edges");
        check({25'd0, irq_idx}, 32'h45, "R9 winner after 4 edges");
        @(negedge clk) src_lines = '0;
        repeat (3) @(posedge clk); #1;
        check({31'd0, irq_out}, 32'd1, "R9 irq_out held 3 edges after release");
        @(posedge clk); #1;
        check({31'd0, irq_out}, 32'd0, "R9 irq_out drops after 4 edges");
        check({25'd0, irq_idx}, 32'd0, "R6 winner clears on release");

        // random patterns
        for (int it = 0; it < 120; it++) begin
            if (it % 8 == 0)
                set_cfg({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));
            @(negedge clk) begin
                case ($urandom % 3)
                    0: src_lines = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
                    1: src_lines = 64'd1 << ($urandom % 64);
                    default: src_lines = {$urandom, $urandom};
                endcase
            end
            settle();
            verify_all("random R1 R3 R4 R6 R7 R8");
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule